// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block arbitrates a set of interrupt request pins for a small processor. Every source has a programmable three-bit priority level, a mask bit and a choice between edge and level triggering. The block tracks which sources are being serviced. It offers the processor at most one source at a time, and only when that source outranks everything already in service. The offer is a valid/ready pair carrying the source index. When the processor accepts it, the source is marked in service. End-of-interrupt commands clear in-service bits again, either by naming a source or by picking the highest-ranked one in service.

Sources 0 and 1 can each front an external slave controller. A per-input cascade bit makes the block pulse a dedicated acknowledge line after that input is accepted, so the slave can put its vector on the bus. A per-input nesting-override bit lets such an input be offered again while its own in-service bit is still set. A slave's higher-ranked request can then nest over its own lower-ranked one. The same bit also lets a single plain pin preempt its own handler. Both bits are ignored for every other source.

Offer rules: `irq_valid` and `irq_id` are registered. `irq_ready` may be held high or low freely. A transfer happens on any clock edge where both are high. The offer is not a holding stream. `irq_valid` may fall without a transfer when the request goes away, and it is always low in the cycle after a transfer.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `cas_ack` are low, every source is masked and edge-triggered at level 0, and the nesting-override and cascade bits are clear.
- R2: In edge mode (`cfg_level`=0), a rising edge on a pin latches a request that stays until it is accepted, and a pin held high does not request again. In level mode (`cfg_level`=1), the latched request is the pin's value from the previous clock.
- R3: Of the eligible requests, the one with the numerically lowest priority level is offered. A tie goes to the lower source index, which is shown on `irq_id`.
- R4: A source whose mask bit (`cfg_mask`=1) is set is never offered.
- R5: A source without the override is offered only when its level is strictly lower than the level of every source in service. When a higher-ranked source preempts, both in-service bits stay set.
- R6: With the override set on source 0 or 1, that source is offered while its own in-service bit is set, provided it outranks every other source in service.
- R7: The override and cascade bits written for sources 2 and above are stored as zero and have no effect.
- R8: A transfer (`irq_valid`&`irq_ready` at an edge) sets the in-service bit of `irq_id` and clears its edge latch, and `irq_valid` is low in the next cycle.
- R9: `cas_ack[k]` (k = 0 or 1) is high for exactly the one cycle after source k is transferred with its cascade bit set. It is low at all other times.
- R10: A non-specific end-of-interrupt (`eoi_specific`=0) clears the in-service bit of the highest-ranked source in service (lowest level, then lowest index).
- R11: A specific end-of-interrupt (`eoi_specific`=1) clears the in-service bit of source `eoi_idx`.
- R12: When an end-of-interrupt and a transfer share an edge, the end-of-interrupt chooses from the in-service bits as they were before that edge, and the transfer's set takes effect.
- R13: `irq_valid` is a registered level. It changes one clock after a change in latched requests, masks, levels or in-service bits, so a pin edge reaches `irq_valid` two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Request pins |
| cfg_we | input | 1 | Write the configuration of one source |
| cfg_idx | input | IDW | Source written |
| cfg_mask | input | 1 | 1 = source masked |
| cfg_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| cfg_sfn | input | 1 | Nesting override (sources 0 and 1 only) |
| cfg_cascade | input | 1 | Cascade acknowledge enable (sources 0 and 1 only) |
| cfg_prio | input | 3 | Priority level, 0 is highest |
| eoi_valid | input | 1 | End-of-interrupt command |
| eoi_specific | input | 1 | 1 = clear `eoi_idx`, 0 = clear highest in service |
| eoi_idx | input | IDW | Source named by a specific end-of-interrupt |
| irq_valid | output | 1 | Interrupt offered to the processor |
| irq_ready | input | 1 | Processor accepts the offer |
| irq_id | output | IDW | Index of the offered source |
| cas_ack | output | 2 | Acknowledge pulses to slave controllers on sources 0 and 1 |

## Verification
The collision of interest is an end-of-interrupt arriving in the same cycle as a transfer. One in-service bit must then be set while the non-specific selection clears another bit, chosen from the state before the edge. The bench provokes this directly. A low-ranked source is put in service, a high-ranked one preempts it, and that transfer is accepted together with a non-specific end-of-interrupt. The outcome is judged at the ports: the low-ranked source's fresh request is blocked, and after one more end-of-interrupt it is offered. Random phases drive `irq_ready`, end-of-interrupt commands and configuration writes independently, so these collisions recur, and every cycle is compared with a bench reference model.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int PRIO_W = 3;
  localparam int NCAS   = 2;
endpackage

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] level,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= irq_in;
      for (int i = 0; i < NSRC; i++) begin
        if (level[i]) pend[i] <= irq_in[i];
        else          pend[i] <= (pend[i] & ~clr[i]) | (irq_in[i] & ~prev_q[i]);
      end
    end
  end
endmodule

// File: rtl/nic_resolver.sv
module nic_resolver import nic_pkg::*; #(
  parameter int NSRC = 4,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]             pend,
  input  logic [NSRC-1:0]             isr,
  input  logic [NSRC-1:0]             mask,
  input  logic [NSRC-1:0]             sfn,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic [NSRC-1:0]             elig,
  output logic                        any,
  output logic [IDW-1:0]              win
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    logic blk;
    always_comb begin
      blk = 1'b0;
      for (int j = 0; j < NSRC; j++) begin
        if (isr[j] && (j != gi || !sfn[gi]) && prio[j] <= prio[gi]) blk = 1'b1;
      end
      elig[gi] = pend[gi] & ~mask[gi] & ~blk;
    end
  end

  always_comb begin
    logic [PRIO_W-1:0] best;
    best = '1;
    any  = 1'b0;
    win  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!any || prio[i] < best)) begin
        any  = 1'b1;
        best = prio[i];
        win  = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/nic_isr.sv
module nic_isr import nic_pkg::*; #(
  parameter int NSRC = 4,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             set_v,
  input  logic                        eoi_valid,
  input  logic                        eoi_specific,
  input  logic [IDW-1:0]              eoi_idx,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic [NSRC-1:0]             isr_q
);
  logic [NSRC-1:0] clr_v;

  always_comb begin
    logic              found;
    logic [PRIO_W-1:0] best;
    logic [IDW-1:0]    top;
    found = 1'b0;
    best  = '1;
    top   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (isr_q[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        best  = prio[i];
        top   = IDW'(i);
      end
    end
    clr_v = '0;
    if (eoi_valid) begin
      if (eoi_specific) clr_v[eoi_idx] = 1'b1;
      else if (found)   clr_v[top]     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl import nic_pkg::*; #(
  parameter int NSRC = 4,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              cfg_we,
  input  logic [IDW-1:0]    cfg_idx,
  input  logic              cfg_mask,
  input  logic              cfg_level,
  input  logic              cfg_sfn,
  input  logic              cfg_cascade,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              eoi_valid,
  input  logic              eoi_specific,
  input  logic [IDW-1:0]    eoi_idx,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [IDW-1:0]    irq_id,
  output logic [NCAS-1:0]   cas_ack
);
  logic [NSRC-1:0]             mask_v, lvl_v, sfn_v;
  logic [NSRC-1:0][PRIO_W-1:0] prio_v;
  logic [NCAS-1:0]             casen_v;
  logic [NSRC-1:0]             pend, isr_q, elig, set_v;
  logic                        any, fire;
  logic [IDW-1:0]              win;

  assign fire = irq_valid & irq_ready;

  always_comb begin
    set_v = '0;
    if (fire) set_v[irq_id] = 1'b1;
  end

  // per-source configuration; override/cascade exist only on cascade-capable inputs
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_v[gi] <= 1'b1;
        lvl_v[gi]  <= 1'b0;
        prio_v[gi] <= '0;
      end else if (cfg_we && cfg_idx == IDW'(gi)) begin
        mask_v[gi] <= cfg_mask;
        lvl_v[gi]  <= cfg_level;
        prio_v[gi] <= cfg_prio;
      end
    end
    if (gi < NCAS) begin : g_casc
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sfn_v[gi]   <= 1'b0;
          casen_v[gi] <= 1'b0;
        end else if (cfg_we && cfg_idx == IDW'(gi)) begin
          sfn_v[gi]   <= cfg_sfn;
          casen_v[gi] <= cfg_cascade;
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) cas_ack[gi] <= 1'b0;
        else        cas_ack[gi] <= fire && irq_id == IDW'(gi) && casen_v[gi];
      end
    end else begin : g_plain
      assign sfn_v[gi] = 1'b0;
    end
  end

  nic_req_latch #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level(lvl_v), .clr(set_v), .pend(pend)
  );

  nic_resolver #(.NSRC(NSRC)) u_res (
    .pend(pend), .isr(isr_q), .mask(mask_v), .sfn(sfn_v), .prio(prio_v),
    .elig(elig), .any(any), .win(win)
  );

  nic_isr #(.NSRC(NSRC)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .eoi_valid(eoi_valid),
    .eoi_specific(eoi_specific), .eoi_idx(eoi_idx), .prio(prio_v), .isr_q(isr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
    end else begin
      irq_valid <= fire ? 1'b0 : any;
      irq_id    <= win;
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker import nic_pkg::*; #(
  parameter int NSRC = 4,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_valid,
  input logic            irq_ready,
  input logic [IDW-1:0]  irq_id,
  input logic [NCAS-1:0] cas_ack,
  input logic [NSRC-1:0] elig,
  input logic [NSRC-1:0] isr,
  input logic [NSRC-1:0] sfn
);
  p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  p_isr_set_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> isr[$past(irq_id)]);

  p_cas_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cas_ack));

  p_cas0_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cas_ack[0] |-> $past(irq_valid && irq_ready && irq_id == '0));

  p_cas1_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cas_ack[1] |-> $past(irq_valid && irq_ready && irq_id == IDW'(1)));

  p_no_self_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elig & isr & ~sfn) == '0);

  p_valid_from_eligible_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(|elig));
endmodule

bind nest_irq_ctrl nic_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_id(irq_id), .cas_ack(cas_ack), .elig(elig), .isr(isr_q), .sfn(sfn_v)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_in = '0;
  logic       cfg_we = 1'b0, cfg_mask = 1'b0, cfg_level = 1'b0, cfg_sfn = 1'b0, cfg_cascade = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [2:0] cfg_prio = '0;
  logic       eoi_valid = 1'b0, eoi_specific = 1'b0;
  logic [1:0] eoi_idx = '0;
  logic       irq_ready = 1'b0;
  logic       irq_valid;
  logic [1:0] irq_id;
  logic [1:0] cas_ack;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nest_irq_ctrl #(.NSRC(N)) u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_sfn(cfg_sfn), .cfg_cascade(cfg_cascade),
    .cfg_prio(cfg_prio), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific), .eoi_idx(eoi_idx),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id), .cas_ack(cas_ack)
  );

  // reference model state
  logic [3:0] m_pend, m_prev, m_isr, m_mask, m_lvl, m_sfn, m_casen;
  logic [2:0] m_prio [4];
  logic       m_valid;
  logic [1:0] m_id, m_cas;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] f_elig();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = 1'b0;
      for (int j = 0; j < 4; j++)
        if (m_isr[j] && (j != i || !m_sfn[i]) && m_prio[j] <= m_prio[i]) b = 1'b1;
      e[i] = m_pend[i] & ~m_mask[i] & ~b;
    end
    return e;
  endfunction

  function automatic logic [2:0] f_best(input logic [3:0] v);
    logic       f;
    logic [1:0] w;
    f = 1'b0; w = '0;
    for (int i = 0; i < 4; i++)
      if (v[i] && (!f || m_prio[i] < m_prio[w])) begin f = 1'b1; w = 2'(i); end
    return {f, w};
  endfunction

  task automatic model_reset();
    m_pend = '0; m_prev = '0; m_isr = '0; m_mask = '1; m_lvl = '0; m_sfn = '0; m_casen = '0;
    for (int i = 0; i < 4; i++) m_prio[i] = '0;
    m_valid = 1'b0; m_id = '0; m_cas = '0;
  endtask

  // one clock: model next state, edge, compare at negedge (R13)
  task automatic step();
    logic       fire;
    logic [2:0] w, t;
    logic [3:0] clr, setv, pn;
    fire = m_valid & irq_ready;
    w = f_best(f_elig());
    t = f_best(m_isr);
    clr = '0;
    if (eoi_valid) begin
      if (eoi_specific) clr[eoi_idx] = 1'b1;
      else if (t[2])    clr[t[1:0]]  = 1'b1;
    end
    setv = '0;
    if (fire) setv[m_id] = 1'b1;
    for (int i = 0; i < 4; i++)
      pn[i] = m_lvl[i] ? irq_in[i] : ((m_pend[i] & ~setv[i]) | (irq_in[i] & ~m_prev[i]));
    @(posedge clk);
    m_cas[0] = fire && m_id == 2'd0 && m_casen[0];
    m_cas[1] = fire && m_id == 2'd1 && m_casen[1];
    m_isr  = (m_isr & ~clr) | setv;
    m_pend = pn;
    m_prev = irq_in;
    m_valid = fire ? 1'b0 : w[2];
    m_id = w[1:0];
    if (cfg_we) begin
      m_mask[cfg_idx] = cfg_mask; m_lvl[cfg_idx] = cfg_level; m_prio[cfg_idx] = cfg_prio;
      m_sfn[cfg_idx]   = (cfg_idx < 2) ? cfg_sfn : 1'b0;
      m_casen[cfg_idx] = (cfg_idx < 2) ? cfg_cascade : 1'b0;
    end
    @(negedge clk);
    chk(irq_valid === m_valid, "R13 model irq_valid", int'(irq_valid), int'(m_valid));
    if (m_valid) chk(irq_id === m_id, "R3 model irq_id", int'(irq_id), int'(m_id));
    chk(cas_ack === m_cas, "R9 model cas_ack", int'(cas_ack), int'(m_cas));
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr(input int idx, input logic mk, input logic lv, input logic sf,
                    input logic cs, input int pr);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_mask = mk; cfg_level = lv; cfg_sfn = sf;
    cfg_cascade = cs; cfg_prio = 3'(pr);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic accept();
    irq_ready = 1'b1; step(); irq_ready = 1'b0;
  endtask

  task automatic eoi(input logic spec, input int idx);
    eoi_valid = 1'b1; eoi_specific = spec; eoi_idx = 2'(idx); step(); eoi_valid = 1'b0;
  endtask

  task automatic expect_offer(input logic v, input int id, input string tag);
    chk(irq_valid === v, tag, int'(irq_valid), int'(v));
    if (v) chk(irq_id === 2'(id), tag, int'(irq_id), id);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(irq_valid === 1'b0, "R1 reset irq_valid", int'(irq_valid), 0);
    chk(cas_ack === 2'b00, "R1 reset cas_ack", int'(cas_ack), 0);

    // R4: masked level source never offered
    wr(3, 1, 1, 0, 0, 5);
    irq_in[3] = 1'b1; steps(3);
    expect_offer(0, 0, "R4 masked source");
    irq_in[3] = 1'b0; step();
    // R2 level mode follows the pin
    wr(3, 0, 1, 0, 0, 5);
    irq_in[3] = 1'b1; steps(2);
    expect_offer(1, 3, "R2 level request");
    irq_in[3] = 1'b0; steps(2);
    expect_offer(0, 0, "R2 level released");

    wr(0, 0, 0, 0, 1, 2);
    wr(1, 0, 0, 0, 1, 1);
    wr(2, 0, 0, 0, 0, 1);
    wr(3, 0, 0, 0, 0, 5);

    // R13 latency, R8 handshake, R2 edge held
    irq_in[3] = 1'b1; step();
    expect_offer(0, 0, "R13 not yet forwarded");
    step();
    expect_offer(1, 3, "R13 forwarded after two clocks");
    accept();
    expect_offer(0, 0, "R8 valid low after transfer");
    step();
    eoi(0, 0); steps(2);
    expect_offer(0, 0, "R2 held edge pin no re-request");
    irq_in = '0; step();

    // R3 tie, R9 cascade, R5 blocking, R11, preemption, R10
    irq_in = 4'b0110; steps(2);
    expect_offer(1, 1, "R3 tie to lower index");
    accept();
    chk(cas_ack === 2'b10, "R9 cas pulse src1", int'(cas_ack), 2);
    step();
    chk(cas_ack === 2'b00, "R9 cas single cycle", int'(cas_ack), 0);
    expect_offer(0, 0, "R5 equal level blocked");
    irq_in[0] = 1'b1; steps(2);
    expect_offer(0, 0, "R5 lower level blocked");
    eoi(1, 1); step();
    expect_offer(1, 2, "R11 specific eoi frees src1");
    accept();
    chk(cas_ack === 2'b00, "R9 no cas for src2", int'(cas_ack), 0);
    wr(0, 0, 0, 0, 1, 0); step();
    expect_offer(1, 0, "R5 preempt by higher level");
    accept();
    chk(cas_ack === 2'b01, "R9 cas pulse src0", int'(cas_ack), 1);
    eoi(0, 0);
    irq_in[0] = 1'b0; step();
    irq_in[0] = 1'b1; steps(2);
    expect_offer(1, 0, "R10 nonspecific eoi cleared src0 only");
    accept(); eoi(0, 0);
    step();
    expect_offer(0, 0, "R5 nested src2 still in service");
    eoi(0, 0);
    irq_in = '0; steps(2);

    // R6 override on src1
    wr(1, 0, 0, 1, 1, 1);
    irq_in[1] = 1'b1; steps(2); accept();
    irq_in[1] = 1'b0; step();
    irq_in[1] = 1'b1; steps(2);
    expect_offer(1, 1, "R6 self nesting on src1");
    accept();
    chk(cas_ack === 2'b10, "R6 cas on nested accept", int'(cas_ack), 2);
    eoi(0, 0); eoi(0, 0);
    irq_in = '0; step();

    // R7 override and cascade ignored on src2
    wr(2, 0, 0, 1, 1, 1);
    irq_in[2] = 1'b1; steps(2); accept();
    chk(cas_ack === 2'b00, "R7 cascade ignored", int'(cas_ack), 0);
    irq_in[2] = 1'b0; step();
    irq_in[2] = 1'b1; steps(3);
    expect_offer(0, 0, "R7 override ignored");
    eoi(0, 0); step();
    expect_offer(1, 2, "R7 latched request after eoi");
    accept(); eoi(0, 0);
    irq_in = '0; step();

    // R12 transfer and eoi in the same cycle
    irq_in[3] = 1'b1; steps(2); accept();
    irq_in[0] = 1'b1; steps(2);
    expect_offer(1, 0, "R12 setup preempt");
    irq_ready = 1'b1; eoi_valid = 1'b1; eoi_specific = 1'b0;
    step();
    irq_ready = 1'b0; eoi_valid = 1'b0;
    irq_in = '0; step();
    irq_in[3] = 1'b1; steps(2);
    expect_offer(0, 0, "R12 transferred source set");
    eoi(0, 0); step();
    expect_offer(1, 3, "R12 older source cleared");
    accept(); eoi(0, 0);
    irq_in = '0; step();

    // R9 cascade off on src0
    wr(0, 0, 0, 0, 0, 0);
    irq_in[0] = 1'b1; steps(2); accept();
    chk(cas_ack === 2'b00, "R9 cascade disabled", int'(cas_ack), 0);
    eoi(0, 0); irq_in = '0; step();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      irq_in = 4'($urandom);
      irq_ready = ($urandom % 3) != 0;
      eoi_valid = ($urandom % 6) == 0;
      eoi_specific = $urandom % 2;
      eoi_idx = 2'($urandom);
      cfg_we = ($urandom % 16) == 0;
      cfg_idx = 2'($urandom);
      cfg_mask = ($urandom % 5) == 0;
      cfg_level = $urandom % 2;
      cfg_sfn = $urandom % 2;
      cfg_cascade = $urandom % 2;
      cfg_prio = 3'($urandom);
      step();
    end
    cfg_we = 1'b0; eoi_valid = 1'b0; irq_ready = 1'b0;
    step();
    summary();
  end
endmodule